// File: doc/BRIEF.md
# I2C-to-SPI Flash Bridge Engine

This block is the command engine behind a byte-level I2C slave. It lets an I2C master drive an SPI flash directly. The slave front end delivers start, stop, write-byte and read-request events. The engine answers every write byte with an ACK or NAK decision and every read request with a data byte. It drives chip select, clock and MOSI for the flash, samples MISO, and keeps a CRC-16 over every byte that crosses the SPI bus.

The engine powers up locked. It only responds after a single write transaction that carries the five unlock bytes. Once unlocked, the first write byte of each transaction is a one-byte opcode:

- The SPI opcodes stream bytes to or from the flash. A frame stays open across many transactions until an explicit release.
- Further opcodes return a status byte, clear the CRC, return either half of the CRC, or lock the engine again.

While an SPI byte is on the wire the engine raises `busy`. This stands for I2C clock stretching, and the front end holds off further events until `busy` drops.

Top module: `i2c_spi_bridge`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `busy` is 0 and the engine is locked.
- R2: While locked, a write byte that equals the next expected unlock byte (0x4D, 0x53, 0x54, 0x41, 0x52 in that order) is ACKed. Any other byte is NAKed and restarts the match. The engine unlocks at a stop only if that transaction held exactly those five bytes; a sixth byte is NAKed and spoils the unlock.
- R3: While locked, opcodes are NAKed, read requests return 0xFF and chip select stays high.
- R4: Opcode 0x10 is ACKed and pulls `spi_cs_n` low. Each later write byte of that transaction is shifted out on MOSI, MSB first. `busy` is high while the byte is shifted, and the byte's ACK comes when it completes.
- R5: After opcode 0x11, each read request clocks one SPI byte with MOSI held at 0x00 and returns the MISO byte. Chip select stays low.
- R6: Opcode 0x12 is ACKed and drives `spi_cs_n` high.
- R7: Opcode 0x20 followed by a read returns the status byte: bit 7 is 1 while unlocked, bit 0 is 1 while chip select is asserted, and the other bits are 0.
- R8: The CRC starts at 0xFFFF and uses polynomial 0x8005, non-reflected, MSB first. It advances once per SPI byte, using the sent byte for opcode 0x10 and the received byte for opcode 0x11. Register reads leave it unchanged.
- R9: Opcode 0x21 sets the CRC to 0xFFFF.
- R10: A read after opcode 0x22 returns CRC bits 15:8, and a read after opcode 0x23 returns bits 7:0.
- R11: Opcode 0x24 is ACKed, releases chip select and locks the engine, so the unlock string is needed again.
- R12: An unknown opcode, and any write byte after an opcode other than 0x10, is NAKed and changes neither chip select nor the CRC.
- R13: SPI runs in mode 0: the clock idles low, toggles only while chip select is low, and stays high for `HALF_DIV` clock cycles per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i2c_start | input | 1 | Start or repeated start seen (pulse) |
| i2c_stop | input | 1 | Stop seen (pulse) |
| wr_valid | input | 1 | Write byte received (pulse) |
| wr_data | input | 8 | Received write byte |
| rd_req | input | 1 | Master requests a read byte (pulse) |
| resp_valid | output | 1 | Response ready (pulse) |
| resp_ack | output | 1 | ACK (1) or NAK (0) for a write byte |
| resp_data | output | 8 | Byte for a read request |
| busy | output | 1 | Stretch request; no events accepted while high |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data out |
| spi_miso | input | 1 | SPI data in |

## Verification
The unlock logic is tried with four streams:
- a clean key, which must unlock;
- a key with a stray byte in the middle, which shows that a mismatch restarts the match;
- a key with a trailing extra byte, which shows that the exact length matters;
- a bare opcode while locked, which shows that commands are ignored.

SPI traffic uses two distinct outgoing bytes and a three-byte read of a varying MISO pattern, so MSB ordering and the MOSI fill value are both visible. Comparing the CRC after sends and after reads shows which byte feeds it. Unknown opcodes and a stray byte after a status opcode are issued with chip select low and a non-initial CRC, so that any leak into either state shows up.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

   localparam logic [7:0] OP_SPI_WR  = 8'h10;
   localparam logic [7:0] OP_SPI_RD  = 8'h11;
   localparam logic [7:0] OP_SPI_END = 8'h12;
   localparam logic [7:0] OP_STATUS  = 8'h20;
   localparam logic [7:0] OP_CRC_CLR = 8'h21;
   localparam logic [7:0] OP_CRC_HI  = 8'h22;
   localparam logic [7:0] OP_CRC_LO  = 8'h23;
   localparam logic [7:0] OP_LOCK    = 8'h24;

   typedef enum logic [2:0] {
      MODE_NONE,
      MODE_SEND,
      MODE_RECV,
      MODE_STAT,
      MODE_CRC_HI,
      MODE_CRC_LO
   } mode_e;

   typedef enum logic {
      ST_IDLE,
      ST_WAIT
   } state_e;

endpackage

// File: rtl/unlock_match.sv
module unlock_match #(
   parameter int          KEY_LEN = 5,
   parameter logic [8*KEY_LEN-1:0] KEY = 40'h4D53544152
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       byte_valid,
   input  logic [7:0] byte_in,
   output logic       hit,
   output logic       complete
);
   localparam int IW = $clog2(KEY_LEN + 1);

   logic [7:0]    key_b [KEY_LEN];
   logic [IW-1:0] idx_q;

   for (genvar g = 0; g < KEY_LEN; g++) begin : g_key
      assign key_b[g] = KEY[8*(KEY_LEN-1-g) +: 8];
   end

   always_comb begin
      hit = 1'b0;
      for (int i = 0; i < KEY_LEN; i++) begin
         if (idx_q == IW'(i) && byte_in == key_b[i]) hit = 1'b1;
      end
   end

   assign complete = (idx_q == IW'(KEY_LEN));

   always_ff @(posedge clk) begin
      if (!rst_n || clr) idx_q <= '0;
      else if (byte_valid) idx_q <= hit ? idx_q + 1'b1 : '0;
   end

endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
   parameter int             CRC_W = 16,
   parameter logic [CRC_W-1:0] POLY = 16'h8005
) (
   input  logic [CRC_W-1:0] crc_in,
   input  logic [7:0]       data,
   output logic [CRC_W-1:0] crc_out
);
   logic [CRC_W-1:0] stage [9];

   assign stage[0] = crc_in;

   for (genvar g = 0; g < 8; g++) begin : g_bit
      logic fb;
      assign fb = stage[g][CRC_W-1] ^ data[7-g];
      assign stage[g+1] = {stage[g][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assign crc_out = stage[8];

endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
   parameter int HALF_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic       shift_busy,
   output logic       done,
   output logic [7:0] rx_byte
);
   localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   logic [DW-1:0] div_q;
   logic [2:0]    bit_q;
   logic [7:0]    sh_q;
   logic          tick;

   assign tick = (div_q == DW'(HALF_DIV - 1));
   assign mosi = sh_q[7];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q      <= '0;
         bit_q      <= '0;
         sh_q       <= '0;
         sck        <= 1'b0;
         shift_busy <= 1'b0;
         done       <= 1'b0;
         rx_byte    <= '0;
      end else begin
         done <= 1'b0;
         if (!shift_busy) begin
            if (go) begin
               sh_q       <= tx_byte;
               bit_q      <= '0;
               div_q      <= '0;
               sck        <= 1'b0;
               shift_busy <= 1'b1;
            end
         end else if (!tick) begin
            div_q <= div_q + 1'b1;
         end else begin
            div_q <= '0;
            if (!sck) begin
               sck     <= 1'b1;
               rx_byte <= {rx_byte[6:0], miso};
            end else begin
               sck <= 1'b0;
               if (bit_q == 3'd7) begin
                  shift_busy <= 1'b0;
                  done       <= 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
                  sh_q  <= {sh_q[6:0], 1'b0};
               end
            end
         end
      end
   end

endmodule

// File: rtl/i2c_spi_bridge.sv
module i2c_spi_bridge
   import bridge_pkg::*;
#(
   parameter int          HALF_DIV  = 2,
   parameter int          KEY_LEN   = 5,
   parameter logic [8*KEY_LEN-1:0] KEY = 40'h4D53544152,
   parameter int          CRC_W     = 16,
   parameter logic [CRC_W-1:0] CRC_POLY = 16'h8005,
   parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF,
   parameter logic [7:0]  FILL_BYTE = 8'h00,
   parameter logic [7:0]  IDLE_BYTE = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       i2c_start,
   input  logic       i2c_stop,
   input  logic       wr_valid,
   input  logic [7:0] wr_data,
   input  logic       rd_req,
   output logic       resp_valid,
   output logic       resp_ack,
   output logic [7:0] resp_data,
   output logic       busy,
   output logic       spi_cs_n,
   output logic       spi_sck,
   output logic       spi_mosi,
   input  logic       spi_miso
);
   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end
   if (KEY_LEN < 1) begin : g_bad_key
      $error("KEY_LEN must be at least 1");
   end
   if (CRC_W < 9 || CRC_W > 16) begin : g_bad_crc
      $error("CRC_W must lie in 9..16 for two byte readout");
   end

   state_e           state_q;
   mode_e            mode_q;
   logic             active, first_q, wait_rd_q, spi_go;
   logic [7:0]       tx_q, spi_rx, crc_feed, status_b;
   logic [CRC_W-1:0] crc_q, crc_next;
   logic             spi_done, shift_busy, key_hit, key_done;
   logic             idle_ev, wr_ev, key_clr, crc_clr;

   assign busy     = (state_q == ST_WAIT);
   assign idle_ev  = (state_q == ST_IDLE);
   assign wr_ev    = idle_ev && !i2c_start && !i2c_stop && wr_valid;
   assign key_clr  = idle_ev && (i2c_start || i2c_stop);
   assign crc_clr  = wr_ev && active && first_q && (wr_data == OP_CRC_CLR);
   assign crc_feed = wait_rd_q ? spi_rx : tx_q;
   assign status_b = {1'b1, 6'b0, ~spi_cs_n};

   unlock_match #(.KEY_LEN(KEY_LEN), .KEY(KEY)) u_key (
      .clk(clk), .rst_n(rst_n), .clr(key_clr),
      .byte_valid(wr_ev && !active), .byte_in(wr_data),
      .hit(key_hit), .complete(key_done)
   );

   crc_byte_step #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .crc_in(crc_q), .data(crc_feed), .crc_out(crc_next)
   );

   spi_byte_shift #(.HALF_DIV(HALF_DIV)) u_spi (
      .clk(clk), .rst_n(rst_n), .go(spi_go), .tx_byte(tx_q),
      .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
      .shift_busy(shift_busy), .done(spi_done), .rx_byte(spi_rx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         mode_q     <= MODE_NONE;
         active     <= 1'b0;
         first_q    <= 1'b1;
         wait_rd_q  <= 1'b0;
         spi_go     <= 1'b0;
         tx_q       <= '0;
         spi_cs_n   <= 1'b1;
         resp_valid <= 1'b0;
         resp_ack   <= 1'b0;
         resp_data  <= IDLE_BYTE;
         crc_q      <= CRC_INIT;
      end else begin
         resp_valid <= 1'b0;
         spi_go     <= 1'b0;
         if (crc_clr) crc_q <= CRC_INIT;
         else if (spi_done) crc_q <= crc_next;

         if (state_q == ST_WAIT) begin
            if (spi_done) begin
               resp_valid <= 1'b1;
               resp_ack   <= 1'b1;
               resp_data  <= wait_rd_q ? spi_rx : IDLE_BYTE;
               state_q    <= ST_IDLE;
            end
         end else if (i2c_start) begin
            first_q <= 1'b1;
         end else if (i2c_stop) begin
            first_q <= 1'b1;
            mode_q  <= MODE_NONE;
            if (!active && key_done) active <= 1'b1;
         end else if (wr_valid) begin
            resp_valid <= 1'b1;
            resp_ack   <= 1'b0;
            if (!active) begin
               resp_ack <= key_hit;
            end else if (first_q) begin
               first_q  <= 1'b0;
               resp_ack <= 1'b1;
               case (wr_data)
                  OP_SPI_WR:  begin spi_cs_n <= 1'b0; mode_q <= MODE_SEND; end
                  OP_SPI_RD:  begin spi_cs_n <= 1'b0; mode_q <= MODE_RECV; end
                  OP_SPI_END: begin spi_cs_n <= 1'b1; mode_q <= MODE_NONE; end
                  OP_STATUS:  mode_q <= MODE_STAT;
                  OP_CRC_CLR: mode_q <= MODE_NONE;
                  OP_CRC_HI:  mode_q <= MODE_CRC_HI;
                  OP_CRC_LO:  mode_q <= MODE_CRC_LO;
                  OP_LOCK: begin
                     active   <= 1'b0;
                     spi_cs_n <= 1'b1;
                     mode_q   <= MODE_NONE;
                  end
                  default: begin resp_ack <= 1'b0; mode_q <= MODE_NONE; end
               endcase
            end else if (mode_q == MODE_SEND) begin
               resp_valid <= 1'b0;
               spi_go     <= 1'b1;
               tx_q       <= wr_data;
               wait_rd_q  <= 1'b0;
               state_q    <= ST_WAIT;
            end
         end else if (rd_req) begin
            if (active && mode_q == MODE_RECV) begin
               spi_go    <= 1'b1;
               tx_q      <= FILL_BYTE;
               wait_rd_q <= 1'b1;
               state_q   <= ST_WAIT;
            end else begin
               resp_valid <= 1'b1;
               resp_ack   <= 1'b1;
               if (!active) resp_data <= IDLE_BYTE;
               else begin
                  case (mode_q)
                     MODE_STAT:   resp_data <= status_b;
                     MODE_CRC_HI: resp_data <= crc_q[CRC_W-1 -: 8];
                     MODE_CRC_LO: resp_data <= crc_q[7:0];
                     default:     resp_data <= IDLE_BYTE;
                  endcase
               end
            end
         end
      end
   end

endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(
   parameter int CRC_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             spi_cs_n,
   input logic             spi_sck,
   input logic             busy,
   input logic             resp_valid,
   input logic             active,
   input logic             shift_busy,
   input logic             spi_done,
   input logic             crc_clr,
   input logic [CRC_W-1:0] crc_q
);
   // R13
   sck_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sck |-> !spi_cs_n);

   // R5
   cs_during_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_busy |-> !spi_cs_n);

   // R3
   locked_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> spi_cs_n);

   // R8
   crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_q != $past(crc_q)) |-> ($past(spi_done) || $past(crc_clr)));

   // R4
   busy_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> resp_valid);

endmodule

bind i2c_spi_bridge bridge_chk #(.CRC_W(CRC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
   .busy(busy), .resp_valid(resp_valid), .active(active),
   .shift_busy(shift_busy), .spi_done(spi_done), .crc_clr(crc_clr),
   .crc_q(crc_q)
);

// File: tb/i2c_spi_bridge_tb.sv
module i2c_spi_bridge_tb;
   localparam int HALF_DIV = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic i2c_start = 0, i2c_stop = 0, wr_valid = 0, rd_req = 0;
   logic [7:0] wr_data = '0;
   logic resp_valid, resp_ack, busy, spi_cs_n, spi_sck, spi_mosi, spi_miso;
   logic [7:0] resp_data;

   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   i2c_spi_bridge #(.HALF_DIV(HALF_DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .i2c_start(i2c_start), .i2c_stop(i2c_stop),
      .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
      .resp_valid(resp_valid), .resp_ack(resp_ack), .resp_data(resp_data),
      .busy(busy), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   // flash model: MISO byte k of a frame is pat(k); MOSI bytes are logged
   function automatic logic [7:0] pat(input int k);
      return 8'h96 ^ 8'(k * 8'h3B);
   endfunction

   int         mbit = 0, mbyte = 0, ncap = 0, nbits = 0, hi_cnt = 0;
   logic [7:0] capsh = '0;
   logic [7:0] cap [64];

   assign spi_miso = pat(mbyte)[7 - mbit];

   always @(negedge spi_sck or posedge spi_cs_n) begin
      if (spi_cs_n) begin mbit <= 0; mbyte <= 0; end
      else if (mbit == 7) begin mbit <= 0; mbyte <= mbyte + 1; end
      else mbit <= mbit + 1;
   end

   always @(posedge spi_sck) begin
      capsh = {capsh[6:0], spi_mosi};
      nbits = nbits + 1;
      if (nbits == 8) begin
         cap[ncap % 64] = capsh;
         ncap = ncap + 1;
         nbits = 0;
      end
   end

   always @(negedge clk) if (spi_sck) hi_cnt <= hi_cnt + 1;

   function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r = c;
      for (int i = 7; i >= 0; i--) begin
         logic fb = r[15] ^ d[i];
         r = {r[14:0], 1'b0};
         if (fb) r = r ^ 16'h8005;
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic ev_start();
      @(negedge clk); i2c_start = 1; @(negedge clk); i2c_start = 0;
   endtask

   task automatic ev_stop();
      @(negedge clk); i2c_stop = 1; @(negedge clk); i2c_stop = 0;
   endtask

   task automatic wait_resp();
      int t = 0;
      while (!resp_valid && t < 4000) begin @(negedge clk); t++; end
      if (!resp_valid) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: no response actual 0 expected 1");
      end
   endtask

   task automatic do_wr(input logic [7:0] b, output logic a);
      @(negedge clk); wr_valid = 1; wr_data = b;
      @(negedge clk); wr_valid = 0;
      wait_resp();
      a = resp_ack;
   endtask

   task automatic do_rd(output logic [7:0] d);
      @(negedge clk); rd_req = 1;
      @(negedge clk); rd_req = 0;
      wait_resp();
      d = resp_data;
   endtask

   task automatic rd_reg(input logic [7:0] op, output logic [7:0] d);
      logic a;
      ev_start(); do_wr(op, a); ev_start(); do_rd(d); ev_stop();
   endtask

   task automatic unlock();
      logic a;
      ev_start();
      do_wr(8'h4D, a); do_wr(8'h53, a); do_wr(8'h54, a);
      do_wr(8'h41, a); do_wr(8'h52, a);
      ev_stop();
   endtask

   // {op, data, expected, requirement}: op 0 start, 1 stop, 2 write, 3 read
   localparam int NV = 21;
   localparam logic [21:0] VEC [NV] = '{
      {2'd0, 8'h00, 8'h00, 4'd3},
      {2'd2, 8'h10, 8'h00, 4'd3},  // R3 opcode while locked is NAKed
      {2'd1, 8'h00, 8'h00, 4'd3},
      {2'd0, 8'h00, 8'h00, 4'd3},
      {2'd3, 8'h00, 8'hFF, 4'd3},  // R3 read while locked gives FF
      {2'd1, 8'h00, 8'h00, 4'd3},
      {2'd0, 8'h00, 8'h00, 4'd2},
      {2'd2, 8'h4D, 8'h01, 4'd2},  // R2 match progress
      {2'd2, 8'h53, 8'h01, 4'd2},
      {2'd2, 8'h00, 8'h00, 4'd2},  // R2 stray byte NAK and restart
      {2'd2, 8'h4D, 8'h01, 4'd2},
      {2'd2, 8'h53, 8'h01, 4'd2},
      {2'd2, 8'h54, 8'h01, 4'd2},
      {2'd2, 8'h41, 8'h01, 4'd2},
      {2'd2, 8'h52, 8'h01, 4'd2},
      {2'd1, 8'h00, 8'h00, 4'd2},
      {2'd0, 8'h00, 8'h00, 4'd7},
      {2'd2, 8'h20, 8'h01, 4'd7},  // R7 status opcode ACK
      {2'd0, 8'h00, 8'h00, 4'd7},
      {2'd3, 8'h00, 8'h80, 4'd7},  // R7 status unlocked, CS high
      {2'd1, 8'h00, 8'h00, 4'd7}
   };

   initial begin
      #(8 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic a;
      logic [7:0] d, hi, lo;
      logic [15:0] crc_exp;
      int base, h0;

      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 cs_n", 16'(spi_cs_n), 16'h1);
      chk("R1 sck", 16'(spi_sck), 16'h0);
      chk("R1 busy", 16'(busy), 16'h0);

      for (int i = 0; i < NV; i++) begin
         case (VEC[i][21:20])
            2'd0: ev_start();
            2'd1: ev_stop();
            2'd2: begin
               do_wr(VEC[i][19:12], a);
               chk($sformatf("R%0d write %h", VEC[i][3:0], VEC[i][19:12]),
                   16'(a), 16'(VEC[i][4]));
            end
            default: begin
               do_rd(d);
               chk($sformatf("R%0d read", VEC[i][3:0]), 16'(d), 16'(VEC[i][11:4]));
            end
         endcase
      end

      // R4 send two bytes, R13 clock timing
      crc_exp = 16'hFFFF;
      base = ncap; h0 = hi_cnt;
      ev_start();
      do_wr(8'h10, a);
      chk("R4 opcode ack", 16'(a), 16'h1);
      chk("R4 cs low", 16'(spi_cs_n), 16'h0);
      @(negedge clk); wr_valid = 1; wr_data = 8'hA5;
      @(negedge clk); wr_valid = 0;
      chk("R4 busy during shift", 16'(busy), 16'h1);
      wait_resp();
      chk("R4 byte ack", 16'(resp_ack), 16'h1);
      do_wr(8'h3C, a);
      ev_stop();
      crc_exp = crc_upd(crc_upd(crc_exp, 8'hA5), 8'h3C);
      chk("R4 mosi byte0", 16'(cap[base % 64]), 16'hA5);
      chk("R4 mosi byte1", 16'(cap[(base + 1) % 64]), 16'h3C);
      chk("R13 sck high cycles", 16'(hi_cnt - h0), 16'(16 * HALF_DIV));

      // R7 status with CS asserted
      rd_reg(8'h20, d);
      chk("R7 status cs low", 16'(d), 16'h81);
      // R8 R10 CRC after sends
      rd_reg(8'h22, hi); rd_reg(8'h23, lo);
      chk("R8 R10 crc after send", {hi, lo}, crc_exp);

      // R6 release
      ev_start(); do_wr(8'h12, a); ev_stop();
      chk("R6 ack", 16'(a), 16'h1);
      chk("R6 cs high", 16'(spi_cs_n), 16'h1);

      // R5 read three bytes
      base = ncap;
      ev_start(); do_wr(8'h11, a); ev_start();
      for (int k = 0; k < 3; k++) begin
         do_rd(d);
         chk($sformatf("R5 miso byte %0d", k), 16'(d), 16'(pat(k)));
         crc_exp = crc_upd(crc_exp, pat(k));
      end
      ev_stop();
      chk("R5 cs still low", 16'(spi_cs_n), 16'h0);
      chk("R5 mosi fill", {cap[base % 64], cap[(base + 2) % 64]}, 16'h0000);

      // R12 unknown opcode and stray byte after status opcode
      ev_start(); do_wr(8'h5E, a); ev_stop();
      chk("R12 unknown NAK", 16'(a), 16'h0);
      chk("R12 cs unchanged", 16'(spi_cs_n), 16'h0);
      ev_start(); do_wr(8'h20, a); do_wr(8'h77, a); ev_stop();
      chk("R12 stray byte NAK", 16'(a), 16'h0);
      rd_reg(8'h22, hi); rd_reg(8'h23, lo);
      chk("R8 R12 crc after receive", {hi, lo}, crc_exp);

      ev_start(); do_wr(8'h12, a); ev_stop();

      // R9 clear
      ev_start(); do_wr(8'h21, a); ev_stop();
      rd_reg(8'h22, hi); rd_reg(8'h23, lo);
      chk("R9 crc cleared", {hi, lo}, 16'hFFFF);

      // R11 lock again, CS released
      ev_start(); do_wr(8'h11, a); do_wr(8'h24, a); ev_stop();
      ev_start(); do_wr(8'h24, a); ev_stop();
      chk("R11 lock ack", 16'(a), 16'h1);
      chk("R11 cs released", 16'(spi_cs_n), 16'h1);
      rd_reg(8'h20, d);
      chk("R11 locked read", 16'(d), 16'hFF);

      // R2 a sixth byte spoils the unlock
      ev_start();
      do_wr(8'h4D, a); do_wr(8'h53, a); do_wr(8'h54, a);
      do_wr(8'h41, a); do_wr(8'h52, a); do_wr(8'h52, a);
      ev_stop();
      chk("R2 sixth byte NAK", 16'(a), 16'h0);
      rd_reg(8'h20, d);
      chk("R2 still locked", 16'(d), 16'hFF);
      unlock();
      rd_reg(8'h20, d);
      chk("R11 unlock again", 16'(d), 16'h80);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule